// File: doc/BRIEF.md
# Eight-Pin I/O Port with Serial-Peripheral Pin Takeover

This block is one eight-pin general-purpose I/O port. Software sets a direction bit and an output bit for each pin through a small register bus, and reads back the pin levels after a two-stage synchronizer. Each pin drives its pad through three signals: an output enable, an output value and a pull-up enable. The pad level returns on a separate input.

An on-chip serial peripheral (SPI) unit and a timer's compare outputs can take over some of the pins. When the SPI unit is enabled, its role decides which pins it forces to input. The clock, slave-select and master-out lines become inputs on a slave. The master-in line becomes an input on a master. A pin that is forced to input keeps its pull-up under control of its output bit. On the pins the SPI unit does not force, its output lines and the compare outputs drive the pad only when software has set that pin to output. The block also sends the synchronized pad levels back to the SPI receive paths and to the timer's capture input. When pin 6 is given to a clock oscillator, the port masks that pin completely.

Top module: `gpio_spi_port`

## Requirements
- R1: After reset, both the direction register and the output register are zero. All pad output enables, pad values and pull-ups are 0.
- R2: A write with `wr_en_i` high stores `wdata_i` at the next clock edge. Address 1 is the direction register and address 2 is the output register. Writes to address 0 or 3 change nothing. `rdata_o` returns the selected register without a clock delay: 0 is the synchronized pin levels, 1 is direction, 2 is output, and 3 reads as 0.
- R3: When a pin is not taken over, `pad_oe_o` equals its direction bit. `pad_out_o` is 0 on any pin whose output enable is 0.
- R4: `pad_pu_o` is 1 exactly when the pin's output enable is 0 and its output-register bit is 1. This also holds while the SPI unit forces the pin to input.
- R5: With `spi_en_i`=1 and `spi_master_i`=0, pins 5, 3 and 2 are forced to input. With `spi_en_i`=1 and `spi_master_i`=1, pin 4 is forced to input. Every other pin follows its direction bit.
- R6: As master, pin 5 drives `spi_sck_mst_i` and pin 3 drives `spi_mosi_mst_i`. As slave, pin 4 drives `spi_miso_slv_i`. Each of these reaches the pad only when the pin's direction bit is 1.
- R7: As master, `spi_miso_mst_o` is synchronized pin 4. As slave, `spi_mosi_slv_o` is synchronized pin 3, `spi_sck_slv_o` is synchronized pin 5 and `spi_ss_n_o` is synchronized pin 2. Any receive path that is not in use reads 0, and `spi_ss_n_o` reads 1 whenever the SPI unit is not an enabled slave.
- R8: When `cmp_en_i[k]` is 1, `cmp_val_i[k]` replaces the output bit of pin k+1 for k=0..2, but only on a pin whose direction bit is 1. If the SPI unit is master, its output on pin 3 takes priority over the compare value.
- R9: A level on `pad_in_i` appears on pin read (address 0) two clock edges after it is applied, and not after one.
- R10: With `osc_sel_i`=1, bit 6 reads as 0 in the pin, direction and output registers, and pad 6 has output enable, value and pull-up all at 0.
- R11: `cap_o` equals synchronized pad 0, with the same two-edge latency as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select (0 pin, 1 direction, 2 output) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| spi_en_i | input | 1 | SPI unit enabled |
| spi_master_i | input | 1 | SPI role: 1 master, 0 slave |
| spi_sck_mst_i | input | 1 | Clock driven by SPI master |
| spi_mosi_mst_i | input | 1 | Data driven by SPI master |
| spi_miso_slv_i | input | 1 | Data driven by SPI slave |
| spi_miso_mst_o | output | 1 | Data received by SPI master |
| spi_mosi_slv_o | output | 1 | Data received by SPI slave |
| spi_sck_slv_o | output | 1 | Clock received by SPI slave |
| spi_ss_n_o | output | 1 | Slave select received by SPI slave, active low |
| cmp_en_i | input | 3 | Compare output enables for pins 1..3 |
| cmp_val_i | input | 3 | Compare output levels for pins 1..3 |
| osc_sel_i | input | 1 | Pin 6 given to oscillator |
| cap_o | output | 1 | Synchronized pin 0 to capture input |
| pad_in_i | input | 8 | Pad levels |
| pad_oe_o | output | 8 | Pad output enables |
| pad_out_o | output | 8 | Pad output values |
| pad_pu_o | output | 8 | Pad pull-up enables |

## Verification
The latency assertion assumes that `pad_in_i` changes only between clock edges, so that every sample of it is settled. The bench drives all inputs on the falling edge and reads the outputs shortly after that, which keeps every input stable around each rising edge. The forcing and masking assertions assume that `spi_en_i`, `spi_master_i` and `osc_sel_i` are static levels and not pulses. The bench changes them only between scenarios, and each scenario settles for a few cycles before it checks anything.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;
  localparam int PIN_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int SYNC_N   = 2;
  localparam int CAP_BIT  = 0;
  localparam int CMP_LO   = 1;
  localparam int CMP_N    = 3;
  localparam int SS_BIT   = 2;
  localparam int MOSI_BIT = 3;
  localparam int MISO_BIT = 4;
  localparam int SCK_BIT  = 5;
  localparam int OSC_BIT  = 6;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/port_regs.sv
module port_regs
  import gpio_spi_pkg::*;
#(
  parameter int W = PIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_i,
  input  logic [W-1:0]      mask_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] dir_q, out_q;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_DIR) dir_q <= wdata_i;
      if (sel == SEL_OUT) out_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PIN: rdata_o = pin_i & ~mask_i;
      SEL_DIR: rdata_o = dir_q & ~mask_i;
      SEL_OUT: rdata_o = out_q & ~mask_i;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_override.sv
module pin_override
  import gpio_spi_pkg::*;
#(
  parameter int W = PIN_W
) (
  input  logic             dir_i,
  input  logic [W-1:0]     dir_vec_i,
  input  logic [W-1:0]     out_i,
  input  logic [W-1:0]     mask_i,
  input  logic             spi_en_i,
  input  logic             spi_master_i,
  input  logic             sck_mst_i,
  input  logic             mosi_mst_i,
  input  logic             miso_slv_i,
  input  logic [CMP_N-1:0] cmp_en_i,
  input  logic [CMP_N-1:0] cmp_val_i,
  output logic [W-1:0]     oe_o,
  output logic [W-1:0]     val_o,
  output logic [W-1:0]     pu_o
);
  logic         slv, mst;
  logic [W-1:0] force_in, drv;

  assign slv = spi_en_i & ~spi_master_i;
  assign mst = spi_en_i & spi_master_i;

  // role-dependent input forcing, differs per pin
  always_comb begin
    force_in           = '0;
    force_in[SCK_BIT]  = slv;
    force_in[MOSI_BIT] = slv;
    force_in[SS_BIT]   = slv;
    force_in[MISO_BIT] = mst;
  end

  // priority: register < compare < SPI
  always_comb begin
    drv = out_i;
    for (int k = 0; k < CMP_N; k++)
      if (cmp_en_i[k]) drv[CMP_LO+k] = cmp_val_i[k];
    if (mst) begin
      drv[SCK_BIT]  = sck_mst_i;
      drv[MOSI_BIT] = mosi_mst_i;
    end
    if (slv) drv[MISO_BIT] = miso_slv_i;
  end

  assign oe_o  = (dir_i ? dir_vec_i : '0) & ~force_in & ~mask_i;
  assign val_o = drv & oe_o;
  assign pu_o  = ~oe_o & out_i & ~mask_i;
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_W-1:0]  wdata_i,
  output logic [PIN_W-1:0]  rdata_o,
  input  logic              spi_en_i,
  input  logic              spi_master_i,
  input  logic              spi_sck_mst_i,
  input  logic              spi_mosi_mst_i,
  input  logic              spi_miso_slv_i,
  output logic              spi_miso_mst_o,
  output logic              spi_mosi_slv_o,
  output logic              spi_sck_slv_o,
  output logic              spi_ss_n_o,
  input  logic [CMP_N-1:0]  cmp_en_i,
  input  logic [CMP_N-1:0]  cmp_val_i,
  input  logic              osc_sel_i,
  output logic              cap_o,
  input  logic [PIN_W-1:0]  pad_in_i,
  output logic [PIN_W-1:0]  pad_oe_o,
  output logic [PIN_W-1:0]  pad_out_o,
  output logic [PIN_W-1:0]  pad_pu_o
);
  logic [PIN_W-1:0] dir_q, out_q, pin_s, osc_mask;
  logic             slv, mst;

  assign osc_mask = osc_sel_i ? PIN_W'(1) << OSC_BIT : '0;
  assign slv      = spi_en_i & ~spi_master_i;
  assign mst      = spi_en_i & spi_master_i;

  pin_sync #(.W(PIN_W), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_s)
  );

  port_regs #(.W(PIN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pin_i   (pin_s),
    .mask_i  (osc_mask),
    .dir_o   (dir_q),
    .out_o   (out_q),
    .rdata_o (rdata_o)
  );

  pin_override #(.W(PIN_W)) u_ovr (
    .dir_i        (1'b1),
    .dir_vec_i    (dir_q),
    .out_i        (out_q),
    .mask_i       (osc_mask),
    .spi_en_i     (spi_en_i),
    .spi_master_i (spi_master_i),
    .sck_mst_i    (spi_sck_mst_i),
    .mosi_mst_i   (spi_mosi_mst_i),
    .miso_slv_i   (spi_miso_slv_i),
    .cmp_en_i     (cmp_en_i),
    .cmp_val_i    (cmp_val_i),
    .oe_o         (pad_oe_o),
    .val_o        (pad_out_o),
    .pu_o         (pad_pu_o)
  );

  // receive paths; idle slave select reads inactive
  assign spi_miso_mst_o = mst & pin_s[MISO_BIT];
  assign spi_mosi_slv_o = slv & pin_s[MOSI_BIT];
  assign spi_sck_slv_o  = slv & pin_s[SCK_BIT];
  assign spi_ss_n_o     = ~slv | pin_s[SS_BIT];
  assign cap_o          = pin_s[CAP_BIT];
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk
  import gpio_spi_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             spi_en_i,
  input logic             spi_master_i,
  input logic             osc_sel_i,
  input logic [PIN_W-1:0] pad_in_i,
  input logic [PIN_W-1:0] dir_q,
  input logic [PIN_W-1:0] pad_oe_o,
  input logic [PIN_W-1:0] pad_pu_o,
  input logic             cap_o,
  input logic             spi_ss_n_o
);
  logic [1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_q <= '0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  AST_OE_NEEDS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_q) == '0);  // R3
  AST_PU_EXCL_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);  // R4
  AST_SLAVE_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_en_i && !spi_master_i) |-> !pad_oe_o[SCK_BIT] && !pad_oe_o[MOSI_BIT] && !pad_oe_o[SS_BIT]);  // R5
  AST_MASTER_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_en_i && spi_master_i) |-> !pad_oe_o[MISO_BIT]);  // R5
  AST_SS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spi_en_i && !spi_master_i) |-> spi_ss_n_o);  // R7
  AST_OSC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_sel_i |-> !pad_oe_o[OSC_BIT] && !pad_pu_o[OSC_BIT]);  // R10
  AST_CAP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd2) |-> cap_o == $past(pad_in_i[CAP_BIT], 2));  // R11
endmodule

bind gpio_spi_port gpio_spi_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .spi_en_i     (spi_en_i),
  .spi_master_i (spi_master_i),
  .osc_sel_i    (osc_sel_i),
  .pad_in_i     (pad_in_i),
  .dir_q        (dir_q),
  .pad_oe_o     (pad_oe_o),
  .pad_pu_o     (pad_pu_o),
  .cap_o        (cap_o),
  .spi_ss_n_o   (spi_ss_n_o)
);

// File: tb/tb_gpio_spi_port.sv
module tb_gpio_spi_port;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       spi_en_i = 1'b0, spi_master_i = 1'b0;
  logic       spi_sck_mst_i = 1'b0, spi_mosi_mst_i = 1'b0, spi_miso_slv_i = 1'b0;
  logic       spi_miso_mst_o, spi_mosi_slv_o, spi_sck_slv_o, spi_ss_n_o;
  logic [2:0] cmp_en_i = '0, cmp_val_i = '0;
  logic       osc_sel_i = 1'b0, cap_o;
  logic [7:0] pad_in_i = '0, pad_oe_o, pad_out_o, pad_pu_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  gpio_spi_port dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    #1;
    chk("R1 oe", pad_oe_o, 8'h00);
    chk("R1 pu", pad_pu_o, 8'h00);
    chk("R1 out", pad_out_o, 8'h00);
    rst_ni = 1'b1;
    settle(1);
    rd(2'd1, d); chk("R1 dir", d, 8'h00);
    rd(2'd2, d); chk("R1 outreg", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    wr(2'd0, 8'hFF); wr(2'd3, 8'hFF);
    settle(1);
    rd(2'd1, d); chk("R2 dir", d, 8'hA5);
    rd(2'd2, d); chk("R2 out", d, 8'h3C);
    rd(2'd3, d); chk("R2 none", d, 8'h00);
    chk("R3 oe", pad_oe_o, 8'hA5);
    chk("R3 val", pad_out_o, 8'h24);
    chk("R4 pu", pad_pu_o, 8'h18);
  endtask

  task automatic t_pullup;
    wr(2'd1, 8'h0F); wr(2'd2, 8'hFF); settle(1);
    chk("R4 pu", pad_pu_o, 8'hF0);
    chk("R3 oe", pad_oe_o, 8'h0F);
    chk("R3 val", pad_out_o, 8'h0F);
  endtask

  task automatic t_spi_slave;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    spi_en_i = 1'b1; spi_master_i = 1'b0; spi_miso_slv_i = 1'b0;
    settle(1);
    chk("R5 slave oe", pad_oe_o, 8'hD3);
    chk("R6 slave val", pad_out_o, 8'hC3);
    chk("R4 forced pu", pad_pu_o, 8'h2C);
    spi_miso_slv_i = 1'b1; #1;
    chk("R6 miso out", pad_out_o, 8'hD3);
    pad_in_i = 8'h28; settle(3);
    chk("R7 mosi_slv", {7'd0, spi_mosi_slv_o}, 8'h01);
    chk("R7 sck_slv", {7'd0, spi_sck_slv_o}, 8'h01);
    chk("R7 ss_n", {7'd0, spi_ss_n_o}, 8'h00);
    chk("R7 miso_mst idle", {7'd0, spi_miso_mst_o}, 8'h00);
  endtask

  task automatic t_spi_master;
    wr(2'd2, 8'h00);
    spi_master_i = 1'b1; spi_sck_mst_i = 1'b1; spi_mosi_mst_i = 1'b0;
    settle(1);
    chk("R5 master oe", pad_oe_o, 8'hEF);
    chk("R6 master val", pad_out_o, 8'h20);
    chk("R4 master pu", pad_pu_o, 8'h00);
    wr(2'd2, 8'hFF); settle(1);
    chk("R6 mosi low", pad_out_o, 8'hE7);
    chk("R4 forced pu", pad_pu_o, 8'h10);
    wr(2'd1, 8'hDF); settle(1);
    chk("R6 sck needs dir", pad_oe_o, 8'hCF);
    pad_in_i = 8'h3C; settle(3);
    chk("R7 miso_mst", {7'd0, spi_miso_mst_o}, 8'h01);
    chk("R7 ss_n idle", {7'd0, spi_ss_n_o}, 8'h01);
    chk("R7 slave paths idle", {6'd0, spi_mosi_slv_o, spi_sck_slv_o}, 8'h00);
  endtask

  task automatic t_compare;
    spi_en_i = 1'b0; spi_master_i = 1'b0; spi_sck_mst_i = 1'b0;
    wr(2'd1, 8'h0E); wr(2'd2, 8'h00);
    cmp_en_i = 3'b111; cmp_val_i = 3'b101; settle(1);
    chk("R8 cmp drive", pad_out_o, 8'h0A);
    wr(2'd1, 8'h00); settle(1);
    chk("R8 cmp needs dir", pad_out_o, 8'h00);
    wr(2'd1, 8'h0E);
    spi_en_i = 1'b1; spi_master_i = 1'b1; spi_mosi_mst_i = 1'b0; settle(1);
    chk("R8 spi wins", pad_out_o, 8'h02);
    spi_en_i = 1'b0; spi_master_i = 1'b0; cmp_en_i = '0; #1;
    chk("R8 cmp off", pad_out_o, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    pad_in_i = 8'h00; settle(3);
    addr_i = 2'd0;
    pad_in_i = 8'h5A;
    @(posedge clk_i); @(negedge clk_i); rd(2'd0, d);
    chk("R9 one edge", d, 8'h00);
    @(posedge clk_i); @(negedge clk_i); rd(2'd0, d);
    chk("R9 two edges", d, 8'h5A);
  endtask

  task automatic t_osc;
    logic [7:0] d;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    pad_in_i = 8'hFF; osc_sel_i = 1'b1; settle(3);
    rd(2'd0, d); chk("R10 pin", d, 8'hBF);
    rd(2'd1, d); chk("R10 dir", d, 8'hBF);
    rd(2'd2, d); chk("R10 out", d, 8'hBF);
    chk("R10 oe", pad_oe_o, 8'hBF);
    wr(2'd1, 8'h00); settle(1);
    chk("R10 pu", pad_pu_o, 8'hBF);
    osc_sel_i = 1'b0; #1;
    chk("R10 release pu", pad_pu_o, 8'hFF);
  endtask

  task automatic t_cap;
    pad_in_i = 8'h00; settle(3);
    pad_in_i = 8'h01;
    @(posedge clk_i); @(negedge clk_i); #1;
    chk("R11 one edge", {7'd0, cap_o}, 8'h00);
    @(posedge clk_i); @(negedge clk_i); #1;
    chk("R11 two edges", {7'd0, cap_o}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    t_regs;
    t_pullup;
    t_spi_slave;
    t_spi_master;
    t_compare;
    t_sync;
    t_osc;
    t_cap;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule